// File: doc/BRIEF.md
# Sector-Erasing Flash Write Sequencer

This block writes a run of 32-bit words into a serial flash through a one-word access port. Words are programmed one at a time at consecutive flash word addresses, starting from an address given with the start pulse. When the sequencer reaches the first word of a sector, it first places an erase command in the flash configuration space for that sector. The sector geometry is not fixed. A device identity word is read from the flash at the start of every run, and the geometry is chosen from it.

Every access uses the same handshake. For a write, the data register is loaded first. Then the address register is written together with a busy flag. The sequencer polls the flag, spaced by a programmable gap, until the flag reports completion. It gives up after a fixed number of polls. Before programming, write enable is raised and the protection word is cleared. At the end of the run write enable is lowered, whether the run succeeded or failed. The result is reported as success, timeout and the failing word address.

The host side supplies the words through a simple indexed read. The sequencer shows the index of the word it needs. The host returns that word combinationally on the same cycle.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `flash_wen`, `fa_addr_we` and `fa_data_we` are all low.
- R2: Every run begins with a read access at data-space address 0xD03AB with `fa_flag` low, issued while `flash_wen` is low. The read completes when `fa_flag_in` reads 1. Bits 7:0 of `fa_rdata` are then the maker code and bits 15:8 the device code.
- R3: Maker code 0xBF selects an offset mask of 0x1FFF and a sector mask of 0x3E000. Any other maker code selects 0x3FFF and 0x3C000.
- R4: The erase command goes to configuration address 0x352 when the maker code is 0xBF and the device code is 0x80. In every other case it goes to 0x3D8.
- R5: Before programming a word whose address ANDed with the offset mask is zero, the block issues an erase write. Its data is built from t = (addr AND sector mask) << 2 as (t & 0xFF00) | ((t << 16) & 0xFF0000) | ((t >> 16) & 0xFF).
- R6: A write access pulses `fa_data_we` with the data, then on the next cycle pulses `fa_addr_we` with `fa_flag` high. The access completes when `fa_flag_in` reads 0. After WR_POLLS unsuccessful polls spaced POLL_GAP cycles apart, it times out.
- R7: After the identity read, `flash_wen` goes high and a write of 0 to configuration address 0x101 follows. The outcome of this write does not stop the run.
- R8: Word i of the run (counted from 0) is programmed at data-space address start_addr + i. Its data is `word_data` as presented while `word_idx` equals i.
- R9: If an erase or program access times out, no further access is issued. The run ends with `timed_out` high, `ok` low and `fail_addr` set to the word address being handled.
- R10: Every run ends with a one-cycle `done` pulse. `flash_wen` is already low at that pulse and stays low while idle.
- R11: If the identity read sees no completion within RD_POLLS polls, its value is taken as 0xDEADDEAD. The run continues with the default geometry and erase address.
- R12: A run with `word_count` zero performs only the identity read and the protection clear, then ends with `ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| start_addr | input | AW | First flash word address |
| word_count | input | CW | Number of words to program |
| word_idx | output | CW | Index of the word currently needed |
| word_data | input | 32 | Word at `word_idx`, valid on the same cycle |
| fa_addr_we | output | 1 | Address register write strobe |
| fa_cfg | output | 1 | 1 selects configuration space, 0 data space |
| fa_addr | output | AW | Access address |
| fa_flag | output | 1 | Flag written with the address (1 = write access) |
| fa_data_we | output | 1 | Data register write strobe |
| fa_wdata | output | 32 | Data register value |
| fa_flag_in | input | 1 | Flag as read back from the port |
| fa_rdata | input | 32 | Data register as read back from the port |
| flash_wen | output | 1 | Flash write enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run completed all words |
| timed_out | output | 1 | Last run stopped on an access timeout |
| fail_addr | output | AW | Word address of the access that timed out |

## Verification
The hardest conditions to reach are the ones where the flash never answers: an erase that stalls, a program that stalls and an identity read that stalls. The bench's port model of the flash flips the flag a fixed delay after each address write. It can be told to withhold the flip for one chosen space and address, or for the identity read. This drives the poll counter to its limit at a chosen point in the run. The poll limits are overridden to small values, so each timeout is reached in a few dozen cycles. Start addresses are placed just below 8K and 16K word boundaries, so that the two geometries disagree about whether an erase is due.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [31:0] ID_WORD_ADDR   = 32'h000D_03AB;
  localparam logic [31:0] UNPROT_ADDR    = 32'h0000_0101;
  localparam logic [31:0] ERASE_CFG_DEF  = 32'h0000_03D8;
  localparam logic [31:0] ERASE_CFG_ALT  = 32'h0000_0352;
  localparam logic [31:0] READ_FALLBACK  = 32'hDEAD_DEAD;
  localparam logic [7:0]  MAKER_SMALL    = 8'hBF;
  localparam logic [7:0]  DEVICE_ALT     = 8'h80;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_UNP, S_NEXT, S_ERS, S_PRG, S_END
  } seq_state_t;

  typedef enum logic [1:0] {
    A_IDLE, A_LOAD, A_ADDR, A_WAIT
  } acc_state_t;

  // Shift the masked sector address left by two, then swap its low and
  // third byte lanes, keeping the middle lane and clearing the top one.
  function automatic logic [31:0] erase_arg(input logic [31:0] masked);
    logic [31:0] t;
    t = masked << 2;
    return {8'h00, t[7:0], t[15:8], t[23:16]};
  endfunction

endpackage

// File: rtl/flash_geom.sv
module flash_geom #(
  parameter int AW = 20
) (
  input  logic [7:0]    maker,
  input  logic [7:0]    device,
  output logic [AW-1:0] off_mask,
  output logic [AW-1:0] sec_mask,
  output logic [AW-1:0] erase_cfg
);
  import flash_seq_pkg::*;

  logic small_sec;

  always_comb begin
    small_sec = (maker == MAKER_SMALL);
    off_mask  = small_sec ? AW'(32'h0_1FFF) : AW'(32'h0_3FFF);
    sec_mask  = small_sec ? AW'(32'h3_E000) : AW'(32'h3_C000);
    erase_cfg = (small_sec && device == DEVICE_ALT) ? AW'(ERASE_CFG_ALT)
                                                     : AW'(ERASE_CFG_DEF);
  end

endmodule

// File: rtl/flash_acc.sv
module flash_acc #(
  parameter int AW       = 20,
  parameter int POLL_GAP = 4,
  parameter int RD_POLLS = 3000,
  parameter int WR_POLLS = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic          go_cfg,
  input  logic [AW-1:0] go_addr,
  input  logic [31:0]   go_wdata,
  output logic          fa_addr_we,
  output logic          fa_data_we,
  output logic          fa_cfg,
  output logic [AW-1:0] fa_addr,
  output logic          fa_flag,
  output logic [31:0]   fa_wdata,
  input  logic          fa_flag_in,
  input  logic [31:0]   fa_rdata,
  output logic          acc_idle,
  output logic          acc_done,
  output logic          acc_to,
  output logic [31:0]   acc_rdata
);
  import flash_seq_pkg::*;

  localparam int MAXP = (RD_POLLS > WR_POLLS) ? RD_POLLS : WR_POLLS;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int GW   = $clog2(POLL_GAP + 1);

  acc_state_t    st_q, st_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          cap_en, gap_end, hit, last;

  always_comb begin
    cap_en   = (st_q == A_IDLE) && go;
    gap_end  = (st_q == A_WAIT) && (gap_q == GW'(POLL_GAP - 1));
    hit      = fa_flag ? !fa_flag_in : fa_flag_in;
    last     = (poll_q == (fa_flag ? PW'(WR_POLLS - 1) : PW'(RD_POLLS - 1)));
    acc_done = gap_end && (hit || last);
    acc_to   = gap_end && !hit && last;
    acc_rdata = acc_to ? READ_FALLBACK : fa_rdata;
    acc_idle   = (st_q == A_IDLE);
    fa_data_we = (st_q == A_LOAD);
    fa_addr_we = (st_q == A_ADDR);
  end

  always_comb begin
    st_d   = st_q;
    gap_d  = gap_q;
    poll_d = poll_q;
    case (st_q)
      A_IDLE: if (go) st_d = go_wr ? A_LOAD : A_ADDR;
      A_LOAD: st_d = A_ADDR;
      A_ADDR: begin
        st_d   = A_WAIT;
        gap_d  = '0;
        poll_d = '0;
      end
      default: begin
        if (acc_done) begin
          st_d = A_IDLE;
        end else if (gap_end) begin
          gap_d  = '0;
          poll_d = poll_q + 1'b1;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= A_IDLE;
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      st_q   <= st_d;
      gap_q  <= gap_d;
      poll_q <= poll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_flag  <= 1'b0;
      fa_cfg   <= 1'b0;
      fa_addr  <= '0;
      fa_wdata <= '0;
    end else if (cap_en) begin
      fa_flag  <= go_wr;
      fa_cfg   <= go_cfg;
      fa_addr  <= go_addr;
      fa_wdata <= go_wdata;
    end
  end

  // R6: the data register is always loaded on the cycle before the address write
  a_r6_load_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fa_data_we |=> fa_addr_we);

  // R6: the controller only launches when the port engine is free
  a_r6_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> acc_idle);

endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl #(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  input  logic [31:0]   word_data,
  output logic [CW-1:0] word_idx,
  output logic [7:0]    maker,
  output logic [7:0]    device,
  input  logic [AW-1:0] off_mask,
  input  logic [AW-1:0] sec_mask,
  input  logic [AW-1:0] erase_cfg,
  input  logic          acc_idle,
  input  logic          acc_done,
  input  logic          acc_to,
  input  logic [31:0]   acc_rdata,
  output logic          go,
  output logic          go_wr,
  output logic          go_cfg,
  output logic [AW-1:0] go_addr,
  output logic [31:0]   go_wdata,
  output logic          flash_wen,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          timed_out,
  output logic [AW-1:0] fail_addr
);
  import flash_seq_pkg::*;

  seq_state_t    st_q, st_d;
  logic          lau_q, lau_d;
  logic [AW-1:0] cur_q, cur_d, fail_d;
  logic [CW-1:0] rem_q, rem_d, idx_d;
  logic [7:0]    mk_d, dv_d;
  logic          wen_d, ok_d, to_d, done_d, issuing;

  always_comb begin
    issuing = (st_q == S_ID) || (st_q == S_UNP) || (st_q == S_ERS) || (st_q == S_PRG);
    go      = issuing && !lau_q && acc_idle;
    go_wr   = (st_q != S_ID);
    go_cfg  = (st_q == S_UNP) || (st_q == S_ERS);
    case (st_q)
      S_ID:    begin go_addr = AW'(ID_WORD_ADDR); go_wdata = '0; end
      S_UNP:   begin go_addr = AW'(UNPROT_ADDR);  go_wdata = '0; end
      S_ERS:   begin go_addr = erase_cfg; go_wdata = erase_arg(32'(cur_q & sec_mask)); end
      default: begin go_addr = cur_q;     go_wdata = word_data; end
    endcase
    busy = (st_q != S_IDLE);
  end

  always_comb begin
    st_d = st_q;   lau_d = lau_q;  cur_d = cur_q;  rem_d = rem_q;
    idx_d = word_idx; mk_d = maker; dv_d = device; wen_d = flash_wen;
    ok_d = ok;     to_d = timed_out; fail_d = fail_addr; done_d = 1'b0;
    if (go)       lau_d = 1'b1;
    if (acc_done) lau_d = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        cur_d = start_addr; rem_d = word_count; idx_d = '0;
        ok_d = 1'b0; to_d = 1'b0; fail_d = '0; st_d = S_ID;
      end
      S_ID: if (acc_done) begin
        mk_d = acc_rdata[7:0]; dv_d = acc_rdata[15:8]; wen_d = 1'b1; st_d = S_UNP;
      end
      S_UNP: if (acc_done) st_d = S_NEXT;
      S_NEXT: begin
        if (rem_q == '0) begin
          ok_d = 1'b1; st_d = S_END;
        end else if ((cur_q & off_mask) == '0) begin
          st_d = S_ERS;
        end else begin
          st_d = S_PRG;
        end
      end
      S_ERS: if (acc_done) begin
        if (acc_to) begin to_d = 1'b1; fail_d = cur_q; st_d = S_END; end
        else st_d = S_PRG;
      end
      S_PRG: if (acc_done) begin
        if (acc_to) begin
          to_d = 1'b1; fail_d = cur_q; st_d = S_END;
        end else begin
          cur_d = cur_q + 1'b1; idx_d = word_idx + 1'b1;
          rem_d = rem_q - 1'b1; st_d = S_NEXT;
        end
      end
      default: begin wen_d = 1'b0; done_d = 1'b1; st_d = S_IDLE; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; lau_q <= 1'b0; cur_q <= '0; rem_q <= '0; word_idx <= '0;
      maker <= '0; device <= '0; flash_wen <= 1'b0; ok <= 1'b0;
      timed_out <= 1'b0; fail_addr <= '0; done <= 1'b0;
    end else begin
      st_q <= st_d; lau_q <= lau_d; cur_q <= cur_d; rem_q <= rem_d; word_idx <= idx_d;
      maker <= mk_d; device <= dv_d; flash_wen <= wen_d; ok <= ok_d;
      timed_out <= to_d; fail_addr <= fail_d; done <= done_d;
    end
  end

  // R5: an erase is only ever issued for a word on a sector boundary
  a_r5_erase_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ERS) |-> ((cur_q & off_mask) == '0));

  // R10: write enable is already off when the end pulse appears
  a_r10_wen_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flash_wen);

  // R10: the end pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW       = 20,
  parameter int CW       = 16,
  parameter int POLL_GAP = 4,
  parameter int RD_POLLS = 3000,
  parameter int WR_POLLS = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  output logic [CW-1:0] word_idx,
  input  logic [31:0]   word_data,
  output logic          fa_addr_we,
  output logic          fa_cfg,
  output logic [AW-1:0] fa_addr,
  output logic          fa_flag,
  output logic          fa_data_we,
  output logic [31:0]   fa_wdata,
  input  logic          fa_flag_in,
  input  logic [31:0]   fa_rdata,
  output logic          flash_wen,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          timed_out,
  output logic [AW-1:0] fail_addr
);

  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [7:0]    maker, device;
  logic [AW-1:0] off_mask, sec_mask, erase_cfg, go_addr;
  logic          go, go_wr, go_cfg, acc_idle, acc_done, acc_to;
  logic [31:0]   go_wdata, acc_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  flash_geom #(.AW(AW)) u_geom (
    .maker(maker), .device(device),
    .off_mask(off_mask), .sec_mask(sec_mask), .erase_cfg(erase_cfg)
  );

  flash_seq_ctl #(.AW(AW), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_s_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .word_data(word_data), .word_idx(word_idx),
    .maker(maker), .device(device), .off_mask(off_mask), .sec_mask(sec_mask),
    .erase_cfg(erase_cfg), .acc_idle(acc_idle), .acc_done(acc_done),
    .acc_to(acc_to), .acc_rdata(acc_rdata), .go(go), .go_wr(go_wr),
    .go_cfg(go_cfg), .go_addr(go_addr), .go_wdata(go_wdata),
    .flash_wen(flash_wen), .busy(busy), .done(done), .ok(ok),
    .timed_out(timed_out), .fail_addr(fail_addr)
  );

  flash_acc #(.AW(AW), .POLL_GAP(POLL_GAP), .RD_POLLS(RD_POLLS),
              .WR_POLLS(WR_POLLS)) u_acc (
    .clk(clk), .rst_n(rst_s_n), .go(go), .go_wr(go_wr), .go_cfg(go_cfg),
    .go_addr(go_addr), .go_wdata(go_wdata), .fa_addr_we(fa_addr_we),
    .fa_data_we(fa_data_we), .fa_cfg(fa_cfg), .fa_addr(fa_addr),
    .fa_flag(fa_flag), .fa_wdata(fa_wdata), .fa_flag_in(fa_flag_in),
    .fa_rdata(fa_rdata), .acc_idle(acc_idle), .acc_done(acc_done),
    .acc_to(acc_to), .acc_rdata(acc_rdata)
  );

  // R7: no write access reaches the port while write enable is off
  a_r7_write_under_wen: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fa_addr_we && fa_flag) |-> flash_wen);

  // R2: the identity read is issued with write enable still off
  a_r2_read_without_wen: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fa_addr_we && !fa_flag) |-> !flash_wen);

endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int CW = 8;
  localparam int GAP = 2;
  localparam int RDP = 4;
  localparam int WRP = 6;
  localparam int LAT = 3;

  typedef struct packed {
    logic          wr;
    logic          cfg;
    logic [AW-1:0] addr;
    logic [31:0]   data;
  } acc_t;

  logic clk, rst_n, start;
  logic [AW-1:0] start_addr, fa_addr, fail_addr;
  logic [CW-1:0] word_count, word_idx;
  logic [31:0] word_data, fa_wdata, fa_rdata;
  logic fa_addr_we, fa_cfg, fa_flag, fa_data_we, fa_flag_in;
  logic flash_wen, busy, done, ok, timed_out;

  int errs = 0, checks = 0;
  bit live = 0;
  acc_t  exp_q[$];
  string tag_q[$];
  logic [31:0] last_data;

  logic [31:0] id_word;
  bit id_dead, stk_en, stk_cfg, stk_q;
  logic [AW-1:0] stk_addr;
  int lat;

  flash_prog_seq #(.AW(AW), .CW(CW), .POLL_GAP(GAP), .RD_POLLS(RDP),
                   .WR_POLLS(WRP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .word_idx(word_idx), .word_data(word_data),
    .fa_addr_we(fa_addr_we), .fa_cfg(fa_cfg), .fa_addr(fa_addr),
    .fa_flag(fa_flag), .fa_data_we(fa_data_we), .fa_wdata(fa_wdata),
    .fa_flag_in(fa_flag_in), .fa_rdata(fa_rdata), .flash_wen(flash_wen),
    .busy(busy), .done(done), .ok(ok), .timed_out(timed_out),
    .fail_addr(fail_addr)
  );

  function automatic logic [31:0] wd(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'hC3, b, ~b, 8'h5A};
  endfunction

  assign word_data = wd(int'(word_idx));
  assign fa_rdata  = id_word;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Port model of the flash: the flag flips LAT edges after an address write,
  // unless the access is one chosen to stall.
  always @(posedge clk) begin
    if (fa_addr_we) begin
      fa_flag_in <= fa_flag;
      lat <= LAT;
      stk_q <= fa_flag ? (stk_en && fa_cfg == stk_cfg && fa_addr == stk_addr) : id_dead;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1 && !stk_q) fa_flag_in <= ~fa_flag_in;
    end
  end

  task automatic chk(input bit cond, input string tg, input string what,
                     input logic [63:0] got, input logic [63:0] expv);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", tg, what, got, expv);
    end
  endtask

  // Reference comparison at every clock: accesses in order, write enable state
  always @(negedge clk) begin
    if (live) begin
      if (!busy) chk(flash_wen == 1'b0, "R10", "wen while idle", 64'(flash_wen), 64'h0);
      if (fa_data_we) last_data = fa_wdata;
      if (fa_addr_we) begin
        acc_t obs;
        obs = '{wr: fa_flag, cfg: fa_cfg, addr: fa_addr,
                data: (fa_flag ? last_data : 32'h0)};
        chk(flash_wen == fa_flag, fa_flag ? "R7" : "R2", "wen at access",
            64'(flash_wen), 64'(fa_flag));
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected access", 64'(obs), 64'h0);
        end else begin
          acc_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(obs == e, t, "access", 64'(obs), 64'(e));
        end
      end
    end
  end

  task automatic push(input bit w, input bit c, input logic [AW-1:0] a,
                      input logic [31:0] d, input string t);
    exp_q.push_back('{wr: w, cfg: c, addr: a, data: d});
    tag_q.push_back(t);
  endtask

  task automatic run_case(input logic [31:0] idw, input bit dead,
                          input logic [AW-1:0] sa, input int n,
                          input bit s_en, input bit s_cfg,
                          input logic [AW-1:0] s_addr, input string tg);
    logic [7:0] mk, dv;
    logic [AW-1:0] offm, secm, ecfg, a, fexp;
    logic [31:0] t, arg;
    bit eok, eto, stop;
    int k;
    id_word = idw; id_dead = dead; stk_en = s_en; stk_cfg = s_cfg; stk_addr = s_addr;
    mk = dead ? 8'hAD : idw[7:0];
    dv = dead ? 8'hDE : idw[15:8];
    offm = (mk == 8'hBF) ? 20'h01FFF : 20'h03FFF;
    secm = (mk == 8'hBF) ? 20'h3E000 : 20'h3C000;
    ecfg = (mk == 8'hBF && dv == 8'h80) ? 20'h00352 : 20'h003D8;
    push(1'b0, 1'b0, 20'hD03AB, 32'h0, "R2");
    push(1'b1, 1'b1, 20'h00101, 32'h0, "R7");
    stop = 0; eto = 0; fexp = '0;
    for (int i = 0; i < n && !stop; i++) begin
      a = sa + AW'(i);
      if ((a & offm) == '0) begin
        t = 32'(a & secm) << 2;
        arg = (t & 32'hFF00) | ((t << 16) & 32'hFF0000) | ((t >> 16) & 32'hFF);
        push(1'b1, 1'b1, ecfg, arg, (dead ? "R11" : "R5"));
        if (s_en && s_cfg && s_addr == ecfg) begin stop = 1; eto = 1; fexp = a; end
      end
      if (!stop) begin
        push(1'b1, 1'b0, a, wd(i), "R8");
        if (s_en && !s_cfg && s_addr == a) begin stop = 1; eto = 1; fexp = a; end
      end
    end
    eok = !eto;
    @(negedge clk);
    start = 1'b1; start_addr = sa; word_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk(done == 1'b1, "R10", {tg, " done pulse"}, 64'(done), 64'h1);
    chk(flash_wen == 1'b0, "R10", {tg, " wen at end"}, 64'(flash_wen), 64'h0);
    chk(ok == eok, (n == 0) ? "R12" : "R9", {tg, " ok"}, 64'(ok), 64'(eok));
    chk(timed_out == eto, "R9", {tg, " timed_out"}, 64'(timed_out), 64'(eto));
    if (eto) chk(fail_addr == fexp, "R9", {tg, " fail_addr"}, 64'(fail_addr), 64'(fexp));
    @(negedge clk);
    chk(done == 1'b0, "R10", {tg, " pulse width"}, 64'(done), 64'h0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8", {tg, " missing accesses"}, 64'(exp_q.size()), 64'h0);
    exp_q.delete(); tag_q.delete();
    stk_en = 0; id_dead = 0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; word_count = '0;
    id_word = '0; id_dead = 0; stk_en = 0; stk_cfg = 0; stk_addr = '0;
    fa_flag_in = 1'b0; lat = 0; stk_q = 0; last_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'h0);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'h0);
    chk(flash_wen == 1'b0, "R1", "wen after reset", 64'(flash_wen), 64'h0);
    chk(fa_addr_we == 1'b0 && fa_data_we == 1'b0, "R1", "strobes after reset",
        64'({fa_addr_we, fa_data_we}), 64'h0);
    live = 1;
    // R3 R4 R5: small sectors, alternate erase address, boundary at 0x2000
    run_case(32'h0000_80BF, 0, 20'h01FFE, 4, 0, 0, '0, "c1");
    // R4: small sectors but other device code, erase goes to default address
    run_case(32'h0000_11BF, 0, 20'h03FFE, 3, 0, 0, '0, "c2");
    // R3: large sectors, no erase at 0x2000
    run_case(32'h0000_0013, 0, 20'h01FFF, 2, 0, 0, '0, "c3");
    // R5: address zero is a sector start
    run_case(32'h0000_0013, 0, 20'h00000, 1, 0, 0, '0, "c4");
    // R6 R9: program stalls at 0x12
    run_case(32'h0000_0013, 0, 20'h00010, 4, 1, 0, 20'h00012, "c5");
    // R6 R9: erase stalls at the alternate erase address
    run_case(32'h0000_80BF, 0, 20'h05FFF, 3, 1, 1, 20'h00352, "c6");
    // R11: identity read stalls, default geometry
    run_case(32'h0000_80BF, 1, 20'h01FFF, 2, 0, 0, '0, "c7");
    // R12: empty run
    run_case(32'h0000_0013, 0, 20'h00100, 0, 0, 0, '0, "c8");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule